// File: doc/BRIEF.md
# Byte-Granular Store Forwarding Merger

This block sits on the data-output side of a cache whose data RAM is written through a pipelined port. A write becomes part of a direct RAM read only three read cycles after it is presented. Each row holds 8 bytes. A write carries a byte mask, or it is a line refill from the bus, which replaces the whole row. Row address and way always come from one shared write channel, whatever the data source.

A load issued in cycle t must see every write issued in cycle t or earlier. So the last three accepted writes are kept in a short pipeline: the current write, a first forwarding stage and a second forwarding stage. For each of the 8 output bytes on its own, the block picks the newest stage that wrote that byte to the same row and tag. If no stage did, it takes the RAM byte of the requested way. Way selection and merging are finished before the clock edge, and the result is placed in an output register. Two partial stores to different bytes of one row therefore both reach a load that follows them.

Top module: `stfwd_merge`

## Requirements
- R1: While reset is asserted and right after it is released, `rdValid` is 0 and `rdData` is all zeros.
- R2: A load accepted in cycle t (`rdEn`=1) gives `rdValid`=1 in cycle t+2 only. In any cycle where `rdValid` is 0, `rdData` keeps its previous value.
- R3: When no forwarded byte applies, each output byte is the stored RAM byte at row `rdRow` of way `rdWay`.
- R4: A write presented in cycle w is stored in RAM for every load issued in cycle w+3 or later, whatever its tag.
- R5: A write presented in cycle t, t-1 or t-2 with the same row and tag as a load issued in cycle t is forwarded to that load, for each byte whose mask bit is set.
- R6: Each byte chooses its source independently, so bytes written by different recent stores to one row are all merged into one load result.
- R7: When several recent matching writes cover the same byte, the newest one supplies it: current cycle, then one cycle before, then two cycles before, then RAM.
- R8: Mask bit i covers data bits 8i+7..8i. Bytes whose mask bit is 0 are neither forwarded nor written, and a store with an all-zero mask changes nothing.
- R9: A write with `wrRefill`=1 uses `rfData` and writes all 8 bytes, ignoring `wrMask` and `stData`.
- R10: A recent write to the same row with a different tag is not forwarded. The load gets the RAM contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write presented this cycle |
| wrRefill | input | 1 | Write is a full-row refill from the bus |
| wrRow | input | ROW_BITS | Row index of the write |
| wrTag | input | TAG_BITS | Tag of the write |
| wrWay | input | WAY_BITS | Way written |
| wrMask | input | 8 | Byte enables of a store |
| stData | input | 64 | Store data |
| rfData | input | 64 | Refill data from the bus |
| rdEn | input | 1 | Load presented this cycle |
| rdRow | input | ROW_BITS | Row index of the load |
| rdTag | input | TAG_BITS | Tag of the load |
| rdWay | input | WAY_BITS | Way holding the load's line |
| rdValid | output | 1 | Load result valid this cycle |
| rdData | output | 64 | Registered load result |

## Verification
Loads are placed zero, one, two and three cycles after a store. The four cases separate the current-write, first-stage, second-stage and RAM paths, so a mis-timed stage shows up as a stale byte. Two partial stores to different bytes followed by one load tell per-byte selection apart from per-row selection. Three stores to the same byte check the priority order. Loads with a different tag, zero-mask stores and refills with garbage store data check R10, R8 and R9. A long random mix on four rows and two tags compares every cycle against a byte-array model that keeps recent writes in a queue.

// File: rtl/stfwd_pkg.sv
`timescale 1ns/1ps
package stfwd_pkg;
  localparam int ROW_BYTES = 8;
  localparam int ROW_W     = ROW_BYTES * 8;

  // per-byte source of the merged load result
  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_NOW  = 2'd1,
    SRC_FWD1 = 2'd2,
    SRC_FWD2 = 2'd3
  } byteSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                          ramWe;
    logic [ROW_BYTES-1:0]          ramByteWe;
    logic                          outLoad;
    byteSrc_e [ROW_BYTES-1:0]      byteSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/stfwd_ctrl.sv
`timescale 1ns/1ps
module stfwd_ctrl
  import stfwd_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int TAG_BITS = 8,
  parameter int WAY_BITS = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         wrRefill,
  input  logic [ROW_BITS-1:0]          wrRow,
  input  logic [TAG_BITS-1:0]          wrTag,
  input  logic [WAY_BITS-1:0]          wrWay,
  input  logic [ROW_BYTES-1:0]         wrMask,
  input  logic                         rdEn,
  input  logic [ROW_BITS-1:0]          rdRow,
  input  logic [TAG_BITS-1:0]          rdTag,
  input  logic [WAY_BITS-1:0]          rdWay,
  output ctrlStrobe_t                  strobe,
  output logic [WAY_BITS+ROW_BITS-1:0] ramAddr,
  output logic [WAY_BITS-1:0]          readWay,
  output logic                         rdValid
);
  // stage 0 = current write, 1 = first forward, 2 = second forward
  localparam int NSTG = 3;

  logic [NSTG-1:0]      sValid;
  logic [ROW_BITS-1:0]  sRow  [NSTG];
  logic [TAG_BITS-1:0]  sTag  [NSTG];
  logic [ROW_BYTES-1:0] sMask [NSTG];
  logic [WAY_BITS-1:0]  s0Way, s1Way;

  logic                 rqValid;
  logic [ROW_BITS-1:0]  rqRow;
  logic [TAG_BITS-1:0]  rqTag;
  logic [WAY_BITS-1:0]  rqWay;

  logic [NSTG-1:0]      stgMatch;
  byteSrc_e [ROW_BYTES-1:0] srcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sValid  <= '0;
      rqValid <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      sValid  <= {sValid[NSTG-2:0], wrEn};
      rqValid <= rdEn;
      rdValid <= rqValid;
    end
  end

  always_ff @(posedge clk) begin
    sRow[0]  <= wrRow;
    sTag[0]  <= wrTag;
    sMask[0] <= wrRefill ? {ROW_BYTES{1'b1}} : wrMask;
    s0Way    <= wrWay;
    s1Way    <= s0Way;
    for (int i = 1; i < NSTG; i++) begin
      sRow[i]  <= sRow[i-1];
      sTag[i]  <= sTag[i-1];
      sMask[i] <= sMask[i-1];
    end
    rqRow <= rdRow;
    rqTag <= rdTag;
    rqWay <= rdWay;
  end

  // row and tag comparison per stage, independent of way
  for (genvar g = 0; g < NSTG; g++) begin : g_match
    assign stgMatch[g] = sValid[g] && (sRow[g] == rqRow) && (sTag[g] == rqTag);
  end

  // per-byte priority: newest matching stage wins
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_sel
    assign srcSel[b] = (stgMatch[0] && sMask[0][b]) ? SRC_NOW  :
                       (stgMatch[1] && sMask[1][b]) ? SRC_FWD1 :
                       (stgMatch[2] && sMask[2][b]) ? SRC_FWD2 : SRC_RAM;
  end

  always_comb begin
    strobe.ramWe     = sValid[1];
    strobe.ramByteWe = sMask[1];
    strobe.outLoad   = rqValid;
    strobe.byteSrc   = srcSel;
  end

  assign ramAddr = {s1Way, sRow[1]};
  assign readWay = rqWay;
endmodule

// File: rtl/stfwd_dpath.sv
`timescale 1ns/1ps
module stfwd_dpath
  import stfwd_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int WAY_BITS = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [WAY_BITS+ROW_BITS-1:0] ramAddr,
  input  logic [WAY_BITS-1:0]          readWay,
  input  logic [ROW_BITS-1:0]          rdRow,
  input  logic                         wrRefill,
  input  logic [ROW_W-1:0]             stData,
  input  logic [ROW_W-1:0]             rfData,
  output logic [ROW_W-1:0]             rdData
);
  localparam int WAYS  = 1 << WAY_BITS;
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int DEPTH = WAYS * ROWS;

  typedef logic [ROW_BYTES-1:0][7:0] row_t;

  row_t sData [3];
  row_t mem   [DEPTH];
  row_t ramQ  [WAYS];
  row_t wayRow, merged, outQ;

  // refill and store share one write channel
  always_ff @(posedge clk) begin
    sData[0] <= wrRefill ? row_t'(rfData) : row_t'(stData);
    sData[1] <= sData[0];
    sData[2] <= sData[1];
  end

  // pipelined RAM write from the first forwarding stage
  always_ff @(posedge clk) begin
    if (strobe.ramWe) begin
      for (int b = 0; b < ROW_BYTES; b++) begin
        if (strobe.ramByteWe[b]) mem[ramAddr][b] <= sData[1][b];
      end
    end
  end

  // synchronous read of every way, old data on a same-edge write
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      ramQ[w] <= mem[{WAY_BITS'(w), rdRow}];
    end
  end

  assign wayRow = ramQ[readWay];

  always_comb begin
    for (int b = 0; b < ROW_BYTES; b++) begin
      case (strobe.byteSrc[b])
        SRC_NOW:  merged[b] = sData[0][b];
        SRC_FWD1: merged[b] = sData[1][b];
        SRC_FWD2: merged[b] = sData[2][b];
        default:  merged[b] = wayRow[b];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outQ <= '0;
    else if (strobe.outLoad) outQ <= merged;
  end

  assign rdData = outQ;
endmodule

// File: rtl/stfwd_merge.sv
`timescale 1ns/1ps
module stfwd_merge
  import stfwd_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int TAG_BITS = 8,
  parameter int WAY_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrRefill,
  input  logic [ROW_BITS-1:0]  wrRow,
  input  logic [TAG_BITS-1:0]  wrTag,
  input  logic [WAY_BITS-1:0]  wrWay,
  input  logic [7:0]           wrMask,
  input  logic [63:0]          stData,
  input  logic [63:0]          rfData,
  input  logic                 rdEn,
  input  logic [ROW_BITS-1:0]  rdRow,
  input  logic [TAG_BITS-1:0]  rdTag,
  input  logic [WAY_BITS-1:0]  rdWay,
  output logic                 rdValid,
  output logic [63:0]          rdData
);
  ctrlStrobe_t                  strobe;
  logic [WAY_BITS+ROW_BITS-1:0] ramAddr;
  logic [WAY_BITS-1:0]          readWay;

  stfwd_ctrl #(.ROW_BITS(ROW_BITS), .TAG_BITS(TAG_BITS), .WAY_BITS(WAY_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrRefill(wrRefill), .wrRow(wrRow), .wrTag(wrTag),
    .wrWay(wrWay), .wrMask(wrMask),
    .rdEn(rdEn), .rdRow(rdRow), .rdTag(rdTag), .rdWay(rdWay),
    .strobe(strobe), .ramAddr(ramAddr), .readWay(readWay), .rdValid(rdValid)
  );

  stfwd_dpath #(.ROW_BITS(ROW_BITS), .WAY_BITS(WAY_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramAddr(ramAddr),
    .readWay(readWay), .rdRow(rdRow), .wrRefill(wrRefill),
    .stData(stData), .rfData(rfData), .rdData(rdData)
  );
endmodule

// File: rtl/stfwd_merge_chk.sv
`timescale 1ns/1ps
module stfwd_merge_chk #(
  parameter int ROW_BITS = 4,
  parameter int TAG_BITS = 8,
  parameter int WAY_BITS = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                wrRefill,
  input logic [ROW_BITS-1:0] wrRow,
  input logic [TAG_BITS-1:0] wrTag,
  input logic [7:0]          wrMask,
  input logic [63:0]         stData,
  input logic [63:0]         rfData,
  input logic                rdEn,
  input logic [ROW_BITS-1:0] rdRow,
  input logic [TAG_BITS-1:0] rdTag,
  input logic                rdValid,
  input logic [63:0]         rdData
);
  logic sameLine;
  assign sameLine = wrEn && rdEn && (wrRow == rdRow) && (wrTag == rdTag);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ##2 rdValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> ##2 !rdValid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));

  p_refill_fwd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sameLine && wrRefill) |-> ##2 (rdData == $past(rfData, 2)));

  p_newest_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sameLine && !wrRefill && (wrMask == 8'hFF)) |-> ##2 (rdData == $past(stData, 2)));
endmodule

bind stfwd_merge stfwd_merge_chk #(
  .ROW_BITS(ROW_BITS), .TAG_BITS(TAG_BITS), .WAY_BITS(WAY_BITS)
) u_chk (.*);

// File: tb/sim_stfwd_merge.sv
`timescale 1ns/1ps
module sim_stfwd_merge;
  localparam int ROW_BITS = 4;
  localparam int TAG_BITS = 8;
  localparam int WAY_BITS = 1;
  localparam int ROWS = 1 << ROW_BITS;
  localparam int WAYS = 1 << WAY_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrRefill = 0, rdEn = 0;
  logic [ROW_BITS-1:0] wrRow = '0, rdRow = '0;
  logic [TAG_BITS-1:0] wrTag = '0, rdTag = '0;
  logic [WAY_BITS-1:0] wrWay = '0, rdWay = '0;
  logic [7:0]  wrMask = '0;
  logic [63:0] stData = '0, rfData = '0;
  logic        rdValid;
  logic [63:0] rdData;

  always #2.5 clk = ~clk;

  stfwd_merge #(.ROW_BITS(ROW_BITS), .TAG_BITS(TAG_BITS), .WAY_BITS(WAY_BITS)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRefill(wrRefill), .wrRow(wrRow),
    .wrTag(wrTag), .wrWay(wrWay), .wrMask(wrMask), .stData(stData), .rfData(rfData),
    .rdEn(rdEn), .rdRow(rdRow), .rdTag(rdTag), .rdWay(rdWay),
    .rdValid(rdValid), .rdData(rdData)
  );

  int checks = 0;
  int failures = 0;
  string curTag = "R3";

  typedef struct {
    bit        v;
    int        row, tag, way;
    bit [7:0]  mask;
    bit [63:0] data;
  } wr_t;

  typedef struct {
    bit        v;
    bit [63:0] data;
    string     tag;
  } exp_t;

  bit [7:0]  rm [WAYS][ROWS][8];
  wr_t       hist[$];
  exp_t      expQ[$];
  bit [63:0] lastData = '0;

  task automatic chk(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one cycle, using the inputs about to be captured
  task automatic modelCycle();
    wr_t  cur;
    exp_t e;
    cur.v    = wrEn;
    cur.row  = int'(wrRow);
    cur.tag  = int'(wrTag);
    cur.way  = int'(wrWay);
    cur.mask = wrRefill ? 8'hFF : wrMask;
    cur.data = wrRefill ? rfData : stData;
    e.v = rdEn;
    e.tag = curTag;
    e.data = '0;
    if (rdEn) begin
      bit [7:0] bytes [8];
      for (int b = 0; b < 8; b++) bytes[b] = rm[rdWay][rdRow][b];
      // overlay oldest to newest among the last three writes
      for (int k = hist.size() - 1; k >= -1; k--) begin
        wr_t h;
        h = (k < 0) ? cur : hist[k];
        if (h.v && h.row == int'(rdRow) && h.tag == int'(rdTag))
          for (int b = 0; b < 8; b++)
            if (h.mask[b]) bytes[b] = h.data[8*b +: 8];
      end
      for (int b = 0; b < 8; b++) e.data[8*b +: 8] = bytes[b];
    end
    expQ.push_back(e);
    if (hist.size() == 2) begin
      wr_t old;
      old = hist.pop_back();
      if (old.v)
        for (int b = 0; b < 8; b++)
          if (old.mask[b]) rm[old.way][old.row][b] = old.data[8*b +: 8];
    end
    hist.push_front(cur);
  endtask

  task automatic tick();
    modelCycle();
    @(negedge clk);
    if (expQ.size() == 2) begin
      exp_t e;
      e = expQ.pop_front();
      chk({e.tag, "/R2 valid"}, rdValid == e.v, 64'(rdValid), 64'(e.v));
      if (e.v) begin
        chk(e.tag, rdData == e.data, rdData, e.data);
        lastData = e.data;
      end else begin
        chk("R2 hold", rdData == lastData, rdData, lastData);
      end
    end
  endtask

  task automatic clrIn();
    wrEn = 0; wrRefill = 0; rdEn = 0; wrMask = '0;
    stData = 64'hDEAD_BEEF_0BAD_F00D;
    rfData = 64'h5555_AAAA_5555_AAAA;
  endtask

  task automatic setWr(int row, int tag, int way, bit [7:0] mask, bit [63:0] d, bit refill);
    wrEn = 1; wrRow = ROW_BITS'(row); wrTag = TAG_BITS'(tag); wrWay = WAY_BITS'(way);
    wrRefill = refill; wrMask = mask;
    if (refill) rfData = d; else stData = d;
  endtask

  task automatic setRd(int row, int tag, int way);
    rdEn = 1; rdRow = ROW_BITS'(row); rdTag = TAG_BITS'(tag); rdWay = WAY_BITS'(way);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin clrIn(); tick(); end
  endtask

  function automatic bit [63:0] pat(int way, int row);
    return {8{8'(way * 16 + row)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clrIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", rdValid == 1'b0, 64'(rdValid), 64'd0);
    chk("R1 data", rdData == 64'd0, rdData, 64'd0);
    rstN = 1'b1;
    chk("R1 after release", rdData == 64'd0 && !rdValid, rdData, 64'd0);

    // R9: fill every way and row by refill (mask and store data ignored)
    curTag = "R9";
    for (int w = 0; w < WAYS; w++)
      for (int r = 0; r < ROWS; r++) begin
        clrIn(); setWr(r, 0, w, 8'h00, pat(w, r), 1'b1); tick();
      end
    idle(3);

    // R3: plain RAM reads, per way
    curTag = "R3";
    for (int w = 0; w < WAYS; w++)
      for (int r = 0; r < ROWS; r++) begin
        clrIn(); setRd(r, 0, w); tick();
      end
    idle(3);

    // R6: two byte stores to different bytes, then a load
    curTag = "R6";
    clrIn(); setWr(5, 0, 0, 8'h02, 64'h0000_0000_0000_1100, 1'b0); tick();
    clrIn(); setWr(5, 0, 0, 8'h40, 64'h0066_0000_0000_0000, 1'b0); tick();
    clrIn(); setRd(5, 0, 0); tick();
    clrIn(); setWr(6, 0, 1, 8'h01, 64'h0000_0000_0000_0077, 1'b0); tick();
    clrIn(); setWr(6, 0, 1, 8'h80, 64'h8800_0000_0000_0000, 1'b0); setRd(6, 0, 1); tick();
    idle(2);

    // R5 / R4: store then load at distance 0,1,2,3
    for (int d = 0; d <= 3; d++) begin
      curTag = (d == 3) ? "R4" : "R5";
      clrIn(); setWr(2, 0, 1, 8'h0F, 64'hFFFF_FFFF_1000_0000 + 64'(d), 1'b0);
      if (d == 0) setRd(2, 0, 1);
      tick();
      for (int k = 1; k <= d; k++) begin
        clrIn(); if (k == d) setRd(2, 0, 1); tick();
      end
      idle(3);
    end
    curTag = "R4";
    clrIn(); setRd(5, 0, 0); tick();
    idle(2);

    // R7: three stores to the same byte, newest wins
    curTag = "R7";
    clrIn(); setWr(3, 0, 0, 8'h08, 64'h0000_0000_AA00_0000, 1'b0); tick();
    clrIn(); setWr(3, 0, 0, 8'h08, 64'h0000_0000_BB00_0000, 1'b0); tick();
    clrIn(); setWr(3, 0, 0, 8'h08, 64'h0000_0000_CC00_0000, 1'b0); setRd(3, 0, 0); tick();
    clrIn(); setRd(3, 0, 0); tick();
    clrIn(); setWr(3, 0, 0, 8'hFF, 64'h1122_3344_5566_7788, 1'b0); setRd(3, 0, 0); tick();
    idle(3);

    // R10: different tag to the same row is not forwarded
    curTag = "R10";
    clrIn(); setWr(7, 1, 1, 8'hFF, 64'hCAFE_CAFE_CAFE_CAFE, 1'b0); tick();
    clrIn(); setRd(7, 0, 1); tick();
    clrIn(); setRd(7, 0, 1); tick();
    idle(2);
    curTag = "R4";
    clrIn(); setRd(7, 0, 1); tick();
    idle(2);

    // R8: zero mask and single top byte
    curTag = "R8";
    clrIn(); setWr(9, 0, 0, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); setRd(9, 0, 0); tick();
    clrIn(); setRd(9, 0, 0); tick();
    clrIn(); setWr(9, 0, 0, 8'h80, 64'h9900_0000_0000_0000, 1'b0); tick();
    clrIn(); setRd(9, 0, 0); tick();
    idle(4);
    clrIn(); setRd(9, 0, 0); tick();
    idle(2);

    // R9: refill forwarded at once and next cycle
    curTag = "R9";
    clrIn(); setWr(11, 0, 1, 8'h00, 64'h0F0E_0D0C_0B0A_0908, 1'b1); setRd(11, 0, 1); tick();
    clrIn(); setRd(11, 0, 1); tick();
    idle(5);

    // R6: random mix on few rows and tags
    curTag = "R6";
    for (int i = 0; i < 600; i++) begin
      clrIn();
      if ($urandom_range(0, 1) == 1)
        setWr($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
              8'($urandom), {$urandom, $urandom}, $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 1) == 1)
        setRd($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
      tick();
    end
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule